// File: doc/BRIEF.md
# Decimal Floating-Point Adder/Subtractor

This block adds or subtracts two unpacked decimal floating-point operands in one clocked step. Each operand is a sign bit, a 10-bit biased binary exponent and a 16-digit BCD significand, with the least significant digit in the lowest nibble. A 2-bit function code selects add or subtract. The sign of operand B is inverted for subtract, and the effective operation is the XOR of the two signs. The operand with the larger exponent is steered to a "large" path. The other operand's significand is shifted right by the exponent gap in whole decimal digits, using a single-pass barrel shifter.

The aligned significands meet in a 17-digit BCD adder built from per-digit cells. Subtraction adds the nines' complement of the aligned operand. An end-around increment is applied when a carry leaves the top digit. When no carry leaves, the sum is complemented again and the result sign is flipped. A sum that reaches the seventeenth digit is truncated to 16 digits, and the exponent is bumped by one. All results are registered. Packing to or from an interchange format, rounding modes and exception flags are handled elsewhere.

Top module: `dfp_addsub`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs become sign 0, exponent 0 and significand 0 after that edge, regardless of the other inputs.
- R2: The result for the inputs present at a rising edge appears on the outputs just after that edge. Before the edge, the outputs keep the previous result.
- R3: Function code `op` = 2'b00 adds and 2'b01 subtracts B from A. Any code with `op[1]` = 1 produces sign 0, exponent 0 and significand 0.
- R4: The effective operation is the magnitude sum when A's sign equals B's sign (after the subtract inversion of B's sign), and the magnitude difference otherwise.
- R5: The operand with the strictly larger exponent is the large operand. On equal exponents, operand A is the large operand.
- R6: The small operand's significand is divided by 10^d with the remainder discarded, where d is the exponent difference. For d of 17 or more it contributes zero.
- R7: For an effective sum, if the 17-digit sum is 10^16 or more, its lowest digit is dropped and the exponent is the large exponent plus one (modulo 1024). Otherwise the significand is the sum and the exponent is the large exponent.
- R8: For an effective difference, the significand is |large − aligned small| and the exponent equals the large exponent.
- R9: The result sign is the large operand's sign. It is inverted when the aligned small magnitude exceeds the large one in an effective difference. A zero significand always carries sign 0.
- R10: Given BCD inputs, every 4-bit nibble of `res_sig` is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 2 | Function code: 00 add, 01 subtract, 1x zero result |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_exp | input | 10 | Biased binary exponent of operand A |
| a_sig | input | 64 | 16-digit BCD significand of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_exp | input | 10 | Biased binary exponent of operand B |
| b_sig | input | 64 | 16-digit BCD significand of operand B |
| res_sign | output | 1 | Registered result sign |
| res_exp | output | 10 | Registered result exponent |
| res_sig | output | 64 | Registered 16-digit BCD result significand |

## Verification
The assertions assume that every nibble of both input significands is a legal decimal digit; the output digit-range property means nothing without that. Both exponents may be any 10-bit value, including the top code where an increment wraps. The stimulus builds every significand digit by digit from values 0 to 9. It mixes exponent pairs that are close, to exercise alignment and carries, with pairs that are far apart, to exercise the flush path.

// File: rtl/dfp_pkg.sv
// Shared constants and the function-code encoding for the decimal
// floating-point adder/subtractor. Assumes 4-bit BCD digits throughout.
package dfp_pkg;
    localparam int SIG_DIGITS = 16;
    localparam int EXP_BITS   = 10;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_OFF0 = 2'b10,
        OP_OFF1 = 2'b11
    } op_e;
endpackage

// File: rtl/bcd_digit_add.sv
// One decimal digit adder cell: a + b + ci with decimal correction.
// Assumes both inputs are legal BCD digits (0..9).
module bcd_digit_add (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       ci,
    output logic [3:0] s,
    output logic       co
);
    logic [4:0] raw;
    logic [4:0] adj;

    // Binary sum, then add six when the digit overflows past nine.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b} + {4'b0, ci};
        adj = raw + 5'd6;
        co  = (raw > 5'd9);
        s   = co ? adj[3:0] : raw[3:0];
    end
endmodule

// File: rtl/bcd_add.sv
// N-digit ripple BCD adder made from bcd_digit_add cells.
// Assumes BCD operands; co is the carry out of the top digit.
module bcd_add #(
    parameter int N = 17
) (
    input  logic [4*N-1:0] a,
    input  logic [4*N-1:0] b,
    input  logic           ci,
    output logic [4*N-1:0] sum,
    output logic           co
);
    logic [N:0] c;

    assign c[0] = ci;
    assign co   = c[N];

    // One cell per digit, carry chained upward.
    for (genvar i = 0; i < N; i++) begin : g_dig
        bcd_digit_add u_cell (
            .a  (a[4*i +: 4]),
            .b  (b[4*i +: 4]),
            .ci (c[i]),
            .s  (sum[4*i +: 4]),
            .co (c[i+1])
        );
    end
endmodule

// File: rtl/bcd_inc.sv
// Adds one to an N-digit BCD value; the carry out of the top digit is
// discarded. Assumes a BCD input.
module bcd_inc #(
    parameter int N = 17
) (
    input  logic [4*N-1:0] din,
    output logic [4*N-1:0] dout
);
    logic [N-1:0] c;

    assign c[0] = 1'b1;

    // A digit rolls to zero and passes the carry on only when it holds nine.
    for (genvar i = 0; i < N; i++) begin : g_dig
        logic nine;
        assign nine = (din[4*i +: 4] == 4'd9);
        assign dout[4*i +: 4] = (c[i] & nine) ? 4'd0 : din[4*i +: 4] + {3'b000, c[i]};
        if (i < N - 1) begin : g_carry
            assign c[i+1] = c[i] & nine;
        end
    end
endmodule

// File: rtl/digit_rshift.sv
// Single-pass barrel shifter moving an N-digit value right by amt whole
// digits. Amounts of N or more give zero. Assumes $clog2(N) <= AMT_W.
module digit_rshift #(
    parameter int N     = 17,
    parameter int AMT_W = 10
) (
    input  logic [4*N-1:0]   din,
    input  logic [AMT_W-1:0] amt,
    output logic [4*N-1:0]   dout
);
    localparam int STAGES = $clog2(N);

    logic [4*N-1:0] stg [0:STAGES];
    logic           flush;

    assign stg[0] = din;
    assign flush  = (amt >= AMT_W'(N));

    // Stage k moves the value by 2**k digits when bit k of the amount is set.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stg[k+1] = amt[k] ? (stg[k] >> (4 * (2 ** k))) : stg[k];
    end

    assign dout = flush ? '0 : stg[STAGES];
endmodule

// File: rtl/dfp_addsub.sv
// Decimal floating-point adder/subtractor on unpacked operands.
// Orders operands by exponent, aligns the smaller one with a digit barrel
// shifter, adds or subtracts in a DIGITS+1 digit BCD adder (nines'
// complement with end-around increment), truncates to DIGITS digits and
// registers sign, exponent and significand. Assumes BCD significands.
module dfp_addsub
    import dfp_pkg::*;
#(
    parameter int DIGITS = SIG_DIGITS,
    parameter int EXP_W  = EXP_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          op,
    input  logic                a_sign,
    input  logic [EXP_W-1:0]    a_exp,
    input  logic [4*DIGITS-1:0] a_sig,
    input  logic                b_sign,
    input  logic [EXP_W-1:0]    b_exp,
    input  logic [4*DIGITS-1:0] b_sig,
    output logic                res_sign,
    output logic [EXP_W-1:0]    res_exp,
    output logic [4*DIGITS-1:0] res_sig
);
    localparam int SIG_W = 4 * DIGITS;
    localparam int WD    = DIGITS + 1;
    localparam int WW    = 4 * WD;

    logic              eff_sub, swap;
    logic              large_sign;
    logic [EXP_W-1:0]  large_exp, small_exp, shift_amt;
    logic [SIG_W-1:0]  large_sig, small_sig;
    logic [WW-1:0]     small_al, addend, raw_sum, inc_sum, sum_nines, mag;
    logic              raw_co, trunc, mag_zero;
    logic              nxt_sign;
    logic [EXP_W-1:0]  nxt_exp;
    logic [SIG_W-1:0]  nxt_sig;

    // Effective operation and operand ordering by exponent.
    always_comb begin
        eff_sub    = a_sign ^ b_sign ^ (op == OP_SUB);
        swap       = (a_exp < b_exp);
        large_sign = swap ? (b_sign ^ (op == OP_SUB)) : a_sign;
        large_exp  = swap ? b_exp : a_exp;
        large_sig  = swap ? b_sig : a_sig;
        small_exp  = swap ? a_exp : b_exp;
        small_sig  = swap ? a_sig : b_sig;
        shift_amt  = large_exp - small_exp;
    end

    digit_rshift #(.N(WD), .AMT_W(EXP_W)) u_align (
        .din  ({4'h0, small_sig}),
        .amt  (shift_amt),
        .dout (small_al)
    );

    // Per-digit nines' complement of the addend and of the raw sum.
    for (genvar i = 0; i < WD; i++) begin : g_nines
        assign addend[4*i +: 4]    = eff_sub ? (4'd9 - small_al[4*i +: 4]) : small_al[4*i +: 4];
        assign sum_nines[4*i +: 4] = 4'd9 - raw_sum[4*i +: 4];
    end

    bcd_add #(.N(WD)) u_add (
        .a   ({4'h0, large_sig}),
        .b   (addend),
        .ci  (1'b0),
        .sum (raw_sum),
        .co  (raw_co)
    );

    bcd_inc #(.N(WD)) u_eac (
        .din  (raw_sum),
        .dout (inc_sum)
    );

    // Magnitude selection, truncation, exponent fix-up and sign.
    always_comb begin
        if (!eff_sub)   mag = raw_sum;
        else if (raw_co) mag = inc_sum;
        else             mag = sum_nines;
        trunc    = (mag[WW-1 -: 4] != 4'h0);
        mag_zero = (mag == '0);
        nxt_sig  = trunc ? mag[WW-1:4] : mag[SIG_W-1:0];
        nxt_exp  = large_exp + EXP_W'(trunc);
        nxt_sign = mag_zero ? 1'b0 : (large_sign ^ (eff_sub & ~raw_co));
        if (op[1]) begin
            nxt_sig  = '0;
            nxt_exp  = '0;
            nxt_sign = 1'b0;
        end
    end

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sign <= 1'b0;
            res_exp  <= '0;
            res_sig  <= '0;
        end else begin
            res_sign <= nxt_sign;
            res_exp  <= nxt_exp;
            res_sig  <= nxt_sig;
        end
    end
endmodule

// File: rtl/dfp_addsub_checker.sv
// Temporal checks on the ports of dfp_addsub. Assumes BCD input significands.
module dfp_addsub_checker #(
    parameter int DIGITS = 16,
    parameter int EXP_W  = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          op,
    input logic                a_sign,
    input logic [EXP_W-1:0]    a_exp,
    input logic                b_sign,
    input logic [EXP_W-1:0]    b_exp,
    input logic                res_sign,
    input logic [EXP_W-1:0]    res_exp,
    input logic [4*DIGITS-1:0] res_sig
);
    logic [EXP_W-1:0] big_exp, big_inc;
    logic             chk_sub;

    // Reference quantities derived from the ports alone.
    always_comb begin
        big_exp = (a_exp >= b_exp) ? a_exp : b_exp;
        big_inc = big_exp + EXP_W'(1);
        chk_sub = a_sign ^ b_sign ^ op[0];
    end

    function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (res_sig == '0 && res_exp == '0 && !res_sign)); // R1
    AST_OFF_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) op[1] |=> (res_sig == '0 && res_exp == '0 && !res_sign)); // R3
    AST_SUM_EXP: assert property (@(posedge clk) disable iff (!rst_n) (!op[1] && !chk_sub) |=> (res_exp == $past(big_exp) || res_exp == $past(big_inc))); // R7
    AST_DIFF_EXP: assert property (@(posedge clk) disable iff (!rst_n) (!op[1] && chk_sub) |=> (res_exp == $past(big_exp))); // R8
    AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) digits_ok(res_sig)); // R10
endmodule

bind dfp_addsub dfp_addsub_checker #(.DIGITS(DIGITS), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op),
    .a_sign(a_sign), .a_exp(a_exp), .b_sign(b_sign), .b_exp(b_exp),
    .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig)
);

// File: tb/dfp_addsub_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random stimulus,
// compared against an integer model of the requirements.
module dfp_addsub_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op;
    logic        a_sign, b_sign;
    logic [9:0]  a_exp, b_exp;
    logic [63:0] a_sig, b_sig;
    logic        res_sign;
    logic [9:0]  res_exp;
    logic [63:0] res_sig;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dfp_addsub uut (
        .clk(clk), .rst_n(rst_n), .op(op),
        .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
        .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
        .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig)
    );

    function automatic longint p10(input int n);
        longint r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    function automatic longint to_int(input logic [63:0] v);
        longint r = 0;
        for (int i = 15; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [63:0] to_bcd(input longint x);
        logic [63:0] r = '0;
        longint      t = x;
        for (int i = 0; i < 16; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [63:0] rand_bcd();
        logic [63:0] r;
        for (int i = 0; i < 16; i++) r[4*i +: 4] = 4'($urandom_range(9, 0));
        return r;
    endfunction

    // Expected {sign, exponent, significand} from the requirements.
    function automatic logic [74:0] model(input logic [1:0] o,
                                          input logic as, input logic [9:0] ae, input logic [63:0] am,
                                          input logic bs, input logic [9:0] be, input logic [63:0] bm);
        logic       bse, sub, ls, sg;
        logic [9:0] le, e;
        longint     lv, sv, sa, m;
        int         d;
        if (o[1]) return '0;
        bse = bs ^ o[0];
        sub = as ^ bse;
        if (ae >= be) begin
            ls = as; le = ae; lv = to_int(am); sv = to_int(bm); d = int'(ae) - int'(be);
        end else begin
            ls = bse; le = be; lv = to_int(bm); sv = to_int(am); d = int'(be) - int'(ae);
        end
        sa = (d >= 17) ? 0 : sv / p10(d);
        e  = le;
        sg = ls;
        if (!sub) begin
            m = lv + sa;
            if (m >= p10(16)) begin
                m = m / 10;
                e = le + 10'd1;
            end
        end else begin
            m = lv - sa;
            if (m < 0) begin
                m  = -m;
                sg = ~ls;
            end
        end
        if (m == 0) sg = 1'b0;
        return {sg, e, to_bcd(m)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [74:0] act, input logic [74:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic as, input logic [9:0] ae, input logic [63:0] am,
                         input logic bs, input logic [9:0] be, input logic [63:0] bm);
        op = o; a_sign = as; a_exp = ae; a_sig = am; b_sign = bs; b_exp = be; b_sig = bm;
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic run(input logic [1:0] o, input logic as, input logic [9:0] ae, input logic [63:0] am,
                       input logic bs, input logic [9:0] be, input logic [63:0] bm, input string tag);
        logic [74:0] exp;
        @(negedge clk);
        drive(o, as, ae, am, bs, be, bm);
        exp = model(o, as, ae, am, bs, be, bm);
        @(negedge clk);
        check({res_sign, res_exp, res_sig} === exp, tag, {res_sign, res_exp, res_sig}, exp);
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [74:0] prev;
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        drive(2'b00, 1'b0, 10'd400, to_bcd(64'd123), 1'b0, 10'd400, to_bcd(64'd456));
        repeat (3) @(negedge clk);
        // R1: reset holds the outputs at zero despite live inputs
        check({res_sign, res_exp, res_sig} === 75'd0, "R1", {res_sign, res_exp, res_sig}, 75'd0);
        rst_n = 1'b1;

        // R7, R10: all-nines plus one carries into the 17th digit
        run(2'b00, 1'b0, 10'd400, to_bcd(64'd9999999999999999), 1'b0, 10'd400, to_bcd(64'd1), "R7");
        check(res_sig === to_bcd(64'd1000000000000000) && res_exp === 10'd401, "R10",
              {res_sign, res_exp, res_sig}, {1'b0, 10'd401, to_bcd(64'd1000000000000000)});
        // R7: increment wraps the exponent at the top code
        run(2'b00, 1'b1, 10'd1023, to_bcd(64'd5000000000000000), 1'b1, 10'd1023, to_bcd(64'd5000000000000001), "R7");
        // R8, R9: larger aligned small operand flips the sign
        run(2'b01, 1'b0, 10'd400, to_bcd(64'd5), 1'b0, 10'd400, to_bcd(64'd7), "R9");
        // R9: exact cancellation gives positive zero
        run(2'b01, 1'b1, 10'd77, to_bcd(64'd4444444444444444), 1'b1, 10'd77, to_bcd(64'd4444444444444444), "R9");
        // R4: differing signs under add become a difference
        run(2'b00, 1'b0, 10'd500, to_bcd(64'd1000), 1'b1, 10'd500, to_bcd(64'd1), "R4");
        // R4: subtract of a negative becomes a sum
        run(2'b01, 1'b0, 10'd500, to_bcd(64'd1000), 1'b1, 10'd500, to_bcd(64'd1), "R4");
        // R5: B has the larger exponent and its sign wins
        run(2'b00, 1'b0, 10'd300, to_bcd(64'd99), 1'b1, 10'd302, to_bcd(64'd8), "R5");
        // R6: gap of 16, 17 and a very large gap
        run(2'b00, 1'b0, 10'd420, to_bcd(64'd1234), 1'b0, 10'd404, to_bcd(64'd9999999999999999), "R6");
        run(2'b00, 1'b0, 10'd421, to_bcd(64'd1234), 1'b0, 10'd404, to_bcd(64'd9999999999999999), "R6");
        run(2'b01, 1'b0, 10'd3, to_bcd(64'd42), 1'b0, 10'd900, to_bcd(64'd17), "R6");
        // R6: partial alignment drops the low digits
        run(2'b00, 1'b0, 10'd610, to_bcd(64'd1000000000000000), 1'b0, 10'd607, to_bcd(64'd123456789), "R6");
        // R3: both off codes force a zero result
        run(2'b10, 1'b1, 10'd610, to_bcd(64'd7), 1'b0, 10'd607, to_bcd(64'd9), "R3");
        run(2'b11, 1'b1, 10'd610, to_bcd(64'd7), 1'b0, 10'd607, to_bcd(64'd9), "R3");

        // R2: new inputs do not reach the outputs before the edge
        run(2'b00, 1'b0, 10'd10, to_bcd(64'd3), 1'b0, 10'd10, to_bcd(64'd4), "R2");
        prev = {res_sign, res_exp, res_sig};
        drive(2'b00, 1'b0, 10'd20, to_bcd(64'd50), 1'b0, 10'd20, to_bcd(64'd60));
        #1;
        check({res_sign, res_exp, res_sig} === prev, "R2", {res_sign, res_exp, res_sig}, prev);
        @(negedge clk);
        check({res_sign, res_exp, res_sig} === {1'b0, 10'd20, to_bcd(64'd110)}, "R2",
              {res_sign, res_exp, res_sig}, {1'b0, 10'd20, to_bcd(64'd110)});

        // R4, R7, R8: seeded random mix of near and far exponents
        for (int n = 0; n < 600; n++) begin
            logic [9:0] ea, eb;
            logic [1:0] o;
            int         r;
            r  = int'($urandom_range(9, 0));
            o  = (r < 9) ? 2'(r % 2) : 2'b11;
            ea = 10'($urandom_range(1023, 0));
            if ($urandom_range(1, 0) == 1) eb = ea + 10'($urandom_range(40, 0)) - 10'd20;
            else                           eb = 10'($urandom_range(1023, 0));
            run(o, 1'($urandom_range(1, 0)), ea, rand_bcd(), 1'($urandom_range(1, 0)), eb, rand_bcd(), "R8");
        end

        // R1: reset in mid-run clears a nonzero result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({res_sign, res_exp, res_sig} === 75'd0, "R1", {res_sign, res_exp, res_sig}, 75'd0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule